// File: doc/BRIEF.md
# Sample-Rate Timer and Interrupt Controller

This block gathers interrupt requests for an audio engine and merges them into a single level-sensitive interrupt line to the host. Four external request pulses feed it: fatal error, parity error, PCM-out service and MIDI service. A fifth request comes from an internal periodic timer. The timer does not count clock cycles. It counts the 48 kHz sample ticks that arrive on `sample_tick`, so its period is written in whole audio samples. A period of 96 (0x60) gives about 500 interrupts per second. The block also keeps a free-running sample-time counter that software can read.

Software reaches the block over a simple register bus. Each access is one cycle long and uses a word address plus separate read and write strobes. Read data is registered and appears one cycle after the read strobe. The register map is:

| Word address | Register | Access |
|---|---|---|
| 0 | configuration | read/write |
| 1 | pending sources | read; write 1 to clear |
| 2 | source enable mask | read/write |
| 3 | timer period | read/write |
| 4 | sample time | read-only |

The four non-timer sources are acknowledged by writing 1 to their bits in the pending-source register. The timer source is acknowledged in a different way: reading the timer-period register clears it.

The timer is a two-state machine:

- **TS_IDLE**: the period is zero and no tick is counted.
- **TS_RUN**: the period is non-zero and each tick advances the count.

The transitions are:

- **start** (TS_IDLE to TS_RUN): a non-zero period is written.
- **stop** (TS_RUN to TS_IDLE): a zero period is written.
- **reload** (TS_RUN to TS_RUN): a non-zero period is written; the count restarts from zero.
- **wrap** (TS_RUN to TS_RUN): the last tick of a period arrives; the count returns to zero and an expiry is raised.

Top module: `sti_irq_top`

## Requirements
- R1: After reset, the configuration, pending, mask, timer-period and sample-time registers all read 0, and `irq_out` is low.
- R2: A one-cycle pulse on a source input sets its pending bit, and the bit stays set until it is acknowledged. The bit positions in the pending-source register (word 1) are: fatal = bit 0, parity = bit 1, PCM-out = bit 5, timer = bit 12, MIDI = bit 13.
- R3: Writing 1 to bit 0, 1, 5 or 13 of word 1 clears that pending bit, and bits written with 0 are unchanged. Writing 1 to bit 12 has no effect on the timer pending bit.
- R4: When a source pulse arrives in the same cycle as its clear (a write-clear or a timer-period read), the bit ends up set.
- R5: With a non-zero period P, the timer pending bit becomes set on every P-th sample tick. Clock cycles without a tick do not advance the count.
- R6: A read of word 3 returns the period in bits 17:0 and clears the timer pending bit. Other pending bits are not affected.
- R7: Writing word 3 loads a new period and restarts the count from zero. A period of 0 stops the timer, and no timer event occurs.
- R8: The period field is 18 bits wide. Write bits above bit 17 are discarded, so the maximum value is 0x3FFFF.
- R9: The enable mask (word 2) uses the same bit layout as word 1. Only bits 0, 1, 5, 12 and 13 are stored; all other bits read 0.
- R10: `irq_out` is high exactly when the global enable (bit 14 of word 0, the only stored bit there) is 1 and some pending bit is also enabled in the mask.
- R11: The sample-time counter (word 4) increases by one on each sample tick, and writes to it are ignored.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd`, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W | Registered read data |
| sample_tick | input | 1 | One-cycle pulse per audio sample |
| ev_fatal | input | 1 | Fatal-error request pulse |
| ev_parity | input | 1 | Parity-error request pulse |
| ev_pcmout | input | 1 | PCM-out service request pulse |
| ev_midi | input | 1 | MIDI service request pulse |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
The assertions take several things for granted about the inputs:
- `sample_tick` and the source requests are synchronous to `clk`.
- A source request lasts exactly one cycle per event.
- `bus_rd` and `bus_wr` are never high in the same cycle.

The bench keeps to these rules. It changes every input only on the falling edge, raises each strobe for exactly one cycle, and never overlaps a read with a write. It drives a tick together with a bus access only where it deliberately tests a collision between an expiry or event and its acknowledge.

// File: rtl/sti_pkg.sv
package sti_pkg;

    localparam int SRC_W       = 16;
    localparam int PERIOD_W    = 18;
    localparam int CFG_GLB_BIT = 14;

    localparam int BIT_FATAL   = 0;
    localparam int BIT_PARITY  = 1;
    localparam int BIT_PCMOUT  = 5;
    localparam int BIT_TIMER   = 12;
    localparam int BIT_MIDI    = 13;

    localparam logic [SRC_W-1:0] SRC_IMPL =
        SRC_W'(1 << BIT_FATAL) | SRC_W'(1 << BIT_PARITY) | SRC_W'(1 << BIT_PCMOUT) |
        SRC_W'(1 << BIT_TIMER) | SRC_W'(1 << BIT_MIDI);
    localparam logic [SRC_W-1:0] SRC_W1C = SRC_IMPL & ~SRC_W'(1 << BIT_TIMER);

    localparam int RA_W = 3;
    localparam logic [RA_W-1:0] RA_CFG   = 3'd0;
    localparam logic [RA_W-1:0] RA_SRC   = 3'd1;
    localparam logic [RA_W-1:0] RA_MASK  = 3'd2;
    localparam logic [RA_W-1:0] RA_TIMER = 3'd3;
    localparam logic [RA_W-1:0] RA_STIME = 3'd4;

    typedef enum logic {
        TS_IDLE = 1'b0,
        TS_RUN  = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/sti_timer.sv
module sti_timer
    import sti_pkg::*;
#(
    parameter int P_W = PERIOD_W,
    parameter int ST_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_tick,
    input  logic            load,
    input  logic [P_W-1:0]  load_val,
    output logic [P_W-1:0]  period_o,
    output logic [ST_W-1:0] stime_o,
    output logic            expire_o
);

    tmr_state_e     state_q, state_d;
    logic [P_W-1:0] period_q;
    logic [P_W-1:0] cnt_q;
    logic [ST_W-1:0] stime_q;
    logic           last_tick;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, stop, reload, wrap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE: if (load && load_val != '0) state_d = TS_RUN;
            TS_RUN:  if (load && load_val == '0) state_d = TS_IDLE;
            default: state_d = TS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        last_tick = (cnt_q == period_q - P_W'(1));
        expire_o  = 1'b0;
        unique case (state_q)
            TS_IDLE: expire_o = 1'b0;
            TS_RUN:  expire_o = sample_tick && !load && last_tick;
            default: expire_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            period_q <= load_val;
            cnt_q    <= '0;
        end else if (state_q == TS_RUN && sample_tick) begin
            cnt_q <= last_tick ? '0 : cnt_q + P_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           stime_q <= '0;
        else if (sample_tick) stime_q <= stime_q + ST_W'(1);
    end

    assign period_o = period_q;
    assign stime_o  = stime_q;

    a_r7_zero_period_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == '0) |-> !expire_o);
    a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_RUN) |-> (cnt_q < period_q));
    a_r5_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_tick && !load) |=> $stable(cnt_q));
    a_r11_stime_step: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> (stime_q == $past(stime_q) + ST_W'(1)));

endmodule

// File: rtl/sti_pending.sv
module sti_pending
    import sti_pkg::*;
#(
    parameter int N = SRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    logic [N-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | ev;
    end

    assign pend = pend_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> pend_q[i]);
        a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !ev[i]) |=> !pend_q[i]);
        a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !clr[i]) |=> pend_q[i]);
    end

endmodule

// File: rtl/sti_regbank.sv
module sti_regbank
    import sti_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int ST_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_W-1:0]  pend,
    input  logic [PERIOD_W-1:0] period,
    input  logic [ST_W-1:0]   stime,
    output logic              glb_en,
    output logic [SRC_W-1:0]  mask,
    output logic [SRC_W-1:0]  clr_vec,
    output logic              tmr_ack,
    output logic              tmr_load,
    output logic [PERIOD_W-1:0] tmr_load_val
);

    logic              hit;
    logic [RA_W-1:0]   ra;
    logic              glb_q;
    logic [SRC_W-1:0]  mask_q;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;

    assign ra  = bus_addr[RA_W-1:0];
    assign hit = (bus_addr >> RA_W) == '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q  <= 1'b0;
            mask_q <= '0;
        end else if (bus_wr && hit) begin
            if (ra == RA_CFG)  glb_q  <= bus_wdata[CFG_GLB_BIT];
            if (ra == RA_MASK) mask_q <= bus_wdata[SRC_W-1:0] & SRC_IMPL;
        end
    end

    always_comb begin
        clr_vec      = '0;
        tmr_load     = 1'b0;
        tmr_ack      = 1'b0;
        tmr_load_val = bus_wdata[PERIOD_W-1:0];
        if (bus_wr && hit && ra == RA_SRC)   clr_vec  = bus_wdata[SRC_W-1:0] & SRC_W1C;
        if (bus_wr && hit && ra == RA_TIMER) tmr_load = 1'b1;
        if (bus_rd && hit && ra == RA_TIMER) tmr_ack  = 1'b1;
    end

    always_comb begin
        rd_val = '0;
        if (hit) begin
            case (ra)
                RA_CFG:   rd_val[CFG_GLB_BIT]    = glb_q;
                RA_SRC:   rd_val[SRC_W-1:0]      = pend;
                RA_MASK:  rd_val[SRC_W-1:0]      = mask_q;
                RA_TIMER: rd_val[PERIOD_W-1:0]   = period;
                RA_STIME: rd_val[ST_W-1:0]       = stime;
                default:  rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;
    assign glb_en    = glb_q;
    assign mask      = mask_q;

    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rdata_q));
    a_r9_mask_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~SRC_IMPL) == '0);

endmodule

// File: rtl/sti_irq_top.sv
module sti_irq_top
    import sti_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int ST_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sample_tick,
    input  logic              ev_fatal,
    input  logic              ev_parity,
    input  logic              ev_pcmout,
    input  logic              ev_midi,
    output logic              irq_out
);

    logic [SRC_W-1:0]    ev_vec, clr_vec, pend, mask, clr_all;
    logic [PERIOD_W-1:0] period, load_val;
    logic [ST_W-1:0]     stime;
    logic                glb_en, tmr_ack, tmr_load, expire;

    sti_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ST_W(ST_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pend(pend),
        .period(period), .stime(stime), .glb_en(glb_en), .mask(mask),
        .clr_vec(clr_vec), .tmr_ack(tmr_ack), .tmr_load(tmr_load),
        .tmr_load_val(load_val)
    );

    sti_timer #(.P_W(PERIOD_W), .ST_W(ST_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .load(tmr_load),
        .load_val(load_val), .period_o(period), .stime_o(stime), .expire_o(expire)
    );

    always_comb begin
        ev_vec             = '0;
        ev_vec[BIT_FATAL]  = ev_fatal;
        ev_vec[BIT_PARITY] = ev_parity;
        ev_vec[BIT_PCMOUT] = ev_pcmout;
        ev_vec[BIT_TIMER]  = expire;
        ev_vec[BIT_MIDI]   = ev_midi;
        clr_all            = clr_vec;
        clr_all[BIT_TIMER] = tmr_ack;
    end

    sti_pending #(.N(SRC_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .ev(ev_vec), .clr(clr_all), .pend(pend)
    );

    assign irq_out = glb_en && ((pend & mask) != '0);

    a_r10_irq_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> glb_en);
    a_r6_read_acks_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ack && !expire) |=> !pend[BIT_TIMER]);
    a_r3_no_w1c_on_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[BIT_TIMER] && !tmr_ack) |=> pend[BIT_TIMER]);

endmodule

// File: tb/tb_sti_irq_top.sv
module tb_sti_irq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        sample_tick = 1'b0;
    logic        ev_fatal = 1'b0, ev_parity = 1'b0, ev_pcmout = 1'b0, ev_midi = 1'b0;
    logic        irq_out;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sti_irq_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .sample_tick(sample_tick), .ev_fatal(ev_fatal), .ev_parity(ev_parity),
        .ev_pcmout(ev_pcmout), .ev_midi(ev_midi), .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sample_tick = 1'b1; @(negedge clk);
            sample_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic pulse(input int which);
        ev_fatal = (which == 0); ev_parity = (which == 1);
        ev_pcmout = (which == 5); ev_midi = (which == 13);
        @(negedge clk);
        ev_fatal = 0; ev_parity = 0; ev_pcmout = 0; ev_midi = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(irq_out == 1'b0, "R1 irq", 32'(irq_out), 0);
        for (int a = 0; a < 5; a++) begin
            rd(4'(a), d);
            chk(d == 0, "R1 reg after reset", d, 0);
        end
    endtask

    task automatic t_sources();
        logic [31:0] d;
        pulse(0); pulse(1); pulse(5); pulse(13);
        rd(4'd1, d);
        chk(d == 32'h2023, "R2 pending bits", d, 32'h2023);
        repeat (3) @(negedge clk);
        rd(4'd1, d);
        chk(d == 32'h2023, "R2 pending sticky", d, 32'h2023);
        chk(irq_out == 1'b0, "R10 masked off", 32'(irq_out), 0);
    endtask

    task automatic t_mask_irq();
        logic [31:0] d;
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, d);
        chk(d == 32'h3023, "R9 mask layout", d, 32'h3023);
        chk(irq_out == 1'b0, "R10 global off", 32'(irq_out), 0);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d);
        chk(d == 32'h4000, "R10 global bit", d, 32'h4000);
        chk(irq_out == 1'b1, "R10 irq on", 32'(irq_out), 1);
        wr(4'd2, 32'h0000_0020);
        chk(irq_out == 1'b1, "R10 single enabled", 32'(irq_out), 1);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(4'd1, 32'h0000_0001);
        rd(4'd1, d);
        chk(d == 32'h2022, "R3 clear fatal only", d, 32'h2022);
        bus_addr = 4'd1; bus_wdata = 32'h2; bus_wr = 1'b1; ev_parity = 1'b1;
        @(negedge clk); bus_wr = 1'b0; ev_parity = 1'b0;
        rd(4'd1, d);
        chk(d == 32'h2022, "R4 event beats clear", d, 32'h2022);
        wr(4'd1, 32'h0000_2022);
        rd(4'd1, d);
        chk(d == 32'h0, "R3 clear all", d, 0);
        chk(irq_out == 1'b0, "R10 irq drops", 32'(irq_out), 0);
    endtask

    task automatic t_timer();
        logic [31:0] d;
        wr(4'd3, 32'd3);
        ticks(2);
        repeat (5) @(negedge clk);
        rd(4'd1, d);
        chk(d == 32'h0, "R5 not yet expired", d, 0);
        ticks(1);
        rd(4'd1, d);
        chk(d == 32'h1000, "R5 expired at 3", d, 32'h1000);
        wr(4'd1, 32'h0000_1000);
        rd(4'd1, d);
        chk(d == 32'h1000, "R3 timer ignores w1c", d, 32'h1000);
        pulse(13);
        rd(4'd3, d);
        chk(d == 32'd3, "R6 period readback", d, 3);
        rd(4'd1, d);
        chk(d == 32'h2000, "R6 timer acked only", d, 32'h2000);
        wr(4'd1, 32'h2000);
        ticks(3);
        rd(4'd1, d);
        chk(d == 32'h1000, "R5 periodic", d, 32'h1000);
        rd(4'd3, d);
        wr(4'd3, 32'd2);
        ticks(1);
        bus_addr = 4'd3; bus_rd = 1'b1; sample_tick = 1'b1;
        @(negedge clk); bus_rd = 1'b0; sample_tick = 1'b0;
        rd(4'd1, d);
        chk(d == 32'h1000, "R4 expiry beats read ack", d, 32'h1000);
        rd(4'd3, d);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        wr(4'd3, 32'd4);
        ticks(2);
        wr(4'd3, 32'd4);
        ticks(2);
        rd(4'd1, d);
        chk(d == 32'h0, "R7 restart from zero", d, 0);
        ticks(2);
        rd(4'd1, d);
        chk(d == 32'h1000, "R7 expiry after reload", d, 32'h1000);
        rd(4'd3, d);
        wr(4'd3, 32'd0);
        ticks(10);
        rd(4'd1, d);
        chk(d == 32'h0, "R7 zero period stops", d, 0);
    endtask

    task automatic t_width();
        logic [31:0] d;
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd3, d);
        chk(d == 32'h3FFFF, "R8 period width", d, 32'h3FFFF);
        wr(4'd3, 32'd0);
    endtask

    task automatic t_stime();
        logic [31:0] a, b;
        rd(4'd4, a);
        ticks(7);
        repeat (4) @(negedge clk);
        rd(4'd4, b);
        chk(b == a + 7, "R11 sample time", b, a + 7);
        wr(4'd4, 32'h1234_5678);
        rd(4'd4, b);
        chk(b == a + 7, "R11 write ignored", b, a + 7);
    endtask

    task automatic t_rdata();
        logic [31:0] d;
        wr(4'd2, 32'h1);
        rd(4'd2, d);
        chk(d == 32'h1, "R12 read next cycle", d, 1);
        wr(4'd2, 32'h2);
        @(negedge clk);
        chk(bus_rdata == 32'h1, "R12 rdata holds", bus_rdata, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sources();
        t_mask_irq();
        t_clear();
        t_timer();
        t_restart();
        t_width();
        t_stime();
        t_rdata();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule